// File: doc/BRIEF.md
# I2C Transfer-Direction and Address-Match Tracker

This block sits beside an I2C controller and keeps two status flags up to date. The direction flag says whether the controller should drive SDA (transmit) or leave it released (receive). The match flag says whether the slave address received in the first byte after a start condition equals the programmed local address. The block also produces an SDA pull-down enable and the count of SCL clocks seen in the first byte.

The block does not shift bits and does not generate start, stop or clock stretching. It consumes single-cycle event pulses from the bit engine: start detected, stop detected, start generated, SCL rising and SCL falling. It also takes the SDA value sampled at each rising edge and the value the controller itself drives. Control strobes from the register side close or release a transfer: communication release, wait release, the enable level and the arbitration-lost level. Enable falling and arbitration-lost rising are turned into one-cycle events inside the block. Each flag updates on the clock edge after its event. If the same cycle holds a condition that sets a flag and one that clears it, the clear wins.

Top module: `i2c_dirmatch_tracker`

## Requirements
- R1: A synchronous active-high `rst` drives `xmit_flag`, `addr_match`, `sda_oe` and `bit_cnt` to 0 on the next clock edge.
- R2: `bit_cnt` becomes 0 one cycle after `start_det`. It then advances by one per `scl_rise` pulse during the first byte and holds at 9 once it reaches 9.
- R3: On the 8th `scl_rise` of the first byte, `addr_match` becomes 1 if the 7 bits sampled on rises 1 to 7 (MSB first) equal `local_addr`. Otherwise it stays 0.
- R4: `addr_match` is cleared by `start_det`, `stop_det`, `comm_rel`, or `iic_en` going from 1 to 0.
- R5: With `role_master`=1, `start_gen` sets `xmit_flag`. A 1 on `sda_drv` at the 8th `scl_rise` of the first byte clears it. A 0 there leaves it set.
- R6: With `role_master`=0, a 1 on `sda_in` at the 8th `scl_rise` of the first byte sets `xmit_flag`, and `start_det` clears it.
- R7: In both roles, `stop_det`, `comm_rel`, `wait_rel`, `iic_en` going 1 to 0, or `arb_lost` going 0 to 1 clears `xmit_flag`. A level held on `iic_en`=0 or `arb_lost`=1 does not block a later set.
- R8: When a set condition and a clear condition for a flag occur in the same cycle, the flag is 0 afterwards.
- R9: `sda_oe` (1 = pull SDA low) is 1 only when all of these hold: `xmit_flag`=1, the falling edge of the first byte's 9th clock has passed since the last start or stop, and `so_latch`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iic_en | input | 1 | Controller enable level |
| role_master | input | 1 | 1 = master role, 0 = slave role |
| start_det | input | 1 | Start condition detected (pulse) |
| stop_det | input | 1 | Stop condition detected (pulse) |
| start_gen | input | 1 | Start condition generated by this controller (pulse) |
| scl_rise | input | 1 | SCL rising edge (pulse) |
| scl_fall | input | 1 | SCL falling edge (pulse) |
| sda_in | input | 1 | SDA value sampled at SCL rise |
| sda_drv | input | 1 | SDA value this controller drives |
| local_addr | input | 7 | Programmed local slave address |
| so_latch | input | 1 | Shift-out latch bit |
| comm_rel | input | 1 | Release-from-communication strobe |
| wait_rel | input | 1 | Wait-release strobe |
| arb_lost | input | 1 | Arbitration-lost level |
| xmit_flag | output | 1 | 1 = transmit direction |
| addr_match | output | 1 | 1 = received address matched |
| sda_oe | output | 1 | Pull SDA low |
| bit_cnt | output | 4 | SCL clocks seen in first byte (0 to 9) |

## Verification
The first byte is sent with the matching address, with an address differing in its LSB, and with each of the two direction-bit values. This separates a match decision from a direction decision, and shows that the match compares every address bit rather than only the top ones. The same byte patterns are run in slave and master roles, so sampled and driven LSBs are told apart. Each clearing strobe is applied alone, with enable and arbitration-lost held at their post-edge levels afterwards, to show edge rather than level behaviour. Conflicting set and clear cycles, plus SCL pulses beyond the ninth, probe the priority and saturation cases.

// File: rtl/i2c_dm_pkg.sv
package i2c_dm_pkg;

    localparam int ADDR_W    = 7;
    localparam int BYTE_CLKS = ADDR_W + 2;
    localparam int CNT_W     = $clog2(BYTE_CLKS + 1);

    typedef enum logic {
        ROLE_SLAVE  = 1'b0,
        ROLE_MASTER = 1'b1
    } role_e;

    // bit-level bus events, each a single-cycle pulse
    typedef struct packed {
        logic start_det;
        logic stop_det;
        logic start_gen;
        logic scl_rise;
        logic scl_fall;
    } bus_ev_t;

    // control-side events after edge conversion
    typedef struct packed {
        logic comm_rel;
        logic wait_rel;
        logic en_fall;
        logic al_rise;
    } ctl_ev_t;

    // events produced at the direction-bit clock of the first byte
    typedef struct packed {
        logic dir_clk;
        logic rx_lsb;
        logic tx_lsb;
        logic hit;
    } addr_ev_t;

    function automatic logic close_event(bus_ev_t b, ctl_ev_t c);
        return b.stop_det | c.comm_rel | c.en_fall;
    endfunction

endpackage

// File: rtl/i2c_dm_edges.sv
module i2c_dm_edges (
    input  logic clk,
    input  logic rst,
    input  logic iic_en,
    input  logic arb_lost,
    output logic en_fall,
    output logic al_rise
);
    logic en_q;
    logic al_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= 1'b0;
            al_q <= 1'b0;
        end else begin
            en_q <= iic_en;
            al_q <= arb_lost;
        end
    end

    assign en_fall = en_q & ~iic_en;
    assign al_rise = arb_lost & ~al_q;

endmodule

// File: rtl/i2c_dm_bytecnt.sv
module i2c_dm_bytecnt
    import i2c_dm_pkg::*;
#(
    parameter  int AW = ADDR_W,
    localparam int CW = $clog2(AW + 3)
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_ev_t       bus,
    input  logic          sda_in,
    input  logic          sda_drv,
    input  logic [AW-1:0] local_addr,
    output addr_ev_t      aev,
    output logic          drive_win,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] DIR_IDX = CW'(AW);
    localparam logic [CW-1:0] LAST    = CW'(AW + 2);

    logic          first_q;
    logic [AW-1:0] sr_q;
    logic          quiet;

    assign quiet = ~bus.start_det & ~bus.stop_det;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            first_q <= 1'b0;
            sr_q    <= '0;
        end else if (bus.start_det) begin
            cnt     <= '0;
            first_q <= 1'b1;
            sr_q    <= '0;
        end else if (bus.stop_det) begin
            first_q <= 1'b0;
        end else if (bus.scl_rise && first_q && cnt != LAST) begin
            cnt <= cnt + 1'b1;
            if (cnt < DIR_IDX)
                sr_q <= {sr_q[AW-2:0], sda_in};
        end else if (bus.scl_fall && first_q && cnt == LAST) begin
            first_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !quiet)
            drive_win <= 1'b0;
        else if (bus.scl_fall && first_q && cnt == LAST)
            drive_win <= 1'b1;
    end

    always_comb begin
        aev.dir_clk = bus.scl_rise & first_q & (cnt == DIR_IDX) & quiet;
        aev.rx_lsb  = sda_in;
        aev.tx_lsb  = sda_drv;
        aev.hit     = (sr_q == local_addr);
    end

    a_r2_cnt_bounded: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);
    a_r2_start_zeroes: assert property (@(posedge clk) disable iff (rst)
        bus.start_det |=> cnt == '0);

endmodule

// File: rtl/i2c_dm_flags.sv
module i2c_dm_flags
    import i2c_dm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  role_e    role,
    input  bus_ev_t  bus,
    input  ctl_ev_t  ctl,
    input  addr_ev_t aev,
    output logic     xmit_q,
    output logic     match_q
);
    logic x_set, x_clr, m_set, m_clr;

    always_comb begin
        x_set = 1'b0;
        x_clr = close_event(bus, ctl) | ctl.wait_rel | ctl.al_rise;
        if (role == ROLE_MASTER) begin
            x_set = bus.start_gen;
            x_clr = x_clr | (aev.dir_clk & aev.tx_lsb);
        end else begin
            x_set = aev.dir_clk & aev.rx_lsb;
            x_clr = x_clr | bus.start_det;
        end
        m_set = aev.dir_clk & aev.hit;
        m_clr = close_event(bus, ctl) | bus.start_det;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            xmit_q  <= 1'b0;
            match_q <= 1'b0;
        end else begin
            if (x_clr)      xmit_q <= 1'b0;
            else if (x_set) xmit_q <= 1'b1;
            if (m_clr)      match_q <= 1'b0;
            else if (m_set) match_q <= 1'b1;
        end
    end

    a_r3_match_needs_dirclk: assert property (@(posedge clk) disable iff (rst)
        $rose(match_q) |-> $past(aev.dir_clk));
    a_r4_stop_clears_match: assert property (@(posedge clk) disable iff (rst)
        bus.stop_det |=> !match_q);
    a_r6_slave_start_clears: assert property (@(posedge clk) disable iff (rst)
        (role == ROLE_SLAVE && bus.start_det) |=> !xmit_q);
    a_r8_wait_rel_wins: assert property (@(posedge clk) disable iff (rst)
        ctl.wait_rel |=> !xmit_q);

endmodule

// File: rtl/i2c_dirmatch_tracker.sv
module i2c_dirmatch_tracker
    import i2c_dm_pkg::*;
#(
    parameter  int AW = ADDR_W,
    localparam int CW = $clog2(AW + 3)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          iic_en,
    input  logic          role_master,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic          start_gen,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          sda_in,
    input  logic          sda_drv,
    input  logic [AW-1:0] local_addr,
    input  logic          so_latch,
    input  logic          comm_rel,
    input  logic          wait_rel,
    input  logic          arb_lost,
    output logic          xmit_flag,
    output logic          addr_match,
    output logic          sda_oe,
    output logic [CW-1:0] bit_cnt
);
    bus_ev_t  bus;
    ctl_ev_t  ctl;
    addr_ev_t aev;
    role_e    role;
    logic     en_fall, al_rise, drive_win;

    assign bus  = '{start_det: start_det, stop_det: stop_det, start_gen: start_gen,
                    scl_rise: scl_rise, scl_fall: scl_fall};
    assign ctl  = '{comm_rel: comm_rel, wait_rel: wait_rel,
                    en_fall: en_fall, al_rise: al_rise};
    assign role = role_master ? ROLE_MASTER : ROLE_SLAVE;

    i2c_dm_edges u_edges (
        .clk(clk), .rst(rst), .iic_en(iic_en), .arb_lost(arb_lost),
        .en_fall(en_fall), .al_rise(al_rise)
    );

    i2c_dm_bytecnt #(.AW(AW)) u_cnt (
        .clk(clk), .rst(rst), .bus(bus), .sda_in(sda_in), .sda_drv(sda_drv),
        .local_addr(local_addr), .aev(aev), .drive_win(drive_win), .cnt(bit_cnt)
    );

    i2c_dm_flags u_flags (
        .clk(clk), .rst(rst), .role(role), .bus(bus), .ctl(ctl), .aev(aev),
        .xmit_q(xmit_flag), .match_q(addr_match)
    );

    assign sda_oe = xmit_flag & drive_win & ~so_latch;

    a_r9_oe_after_ninth: assert property (@(posedge clk) disable iff (rst)
        sda_oe |-> bit_cnt == CW'(AW + 2));

endmodule

// File: tb/i2c_dirmatch_tracker_test.sv
`timescale 1ns/1ps
module i2c_dirmatch_tracker_test;

    localparam logic [6:0] OWN = 7'h2D;

    logic clk = 1'b0;
    logic rst, iic_en, role_master, start_det, stop_det, start_gen;
    logic scl_rise, scl_fall, sda_in, sda_drv, so_latch, comm_rel, wait_rel, arb_lost;
    logic [6:0] local_addr;
    logic xmit_flag, addr_match, sda_oe;
    logic [3:0] bit_cnt;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference model state
    int m_cnt, m_addr;
    bit m_first, m_x, m_m, m_win, en_prev, al_prev;
    bit ef, ar, r8, xs, xc, ms, mc, nwin;

    always #5 clk = ~clk;

    i2c_dirmatch_tracker uut (
        .clk(clk), .rst(rst), .iic_en(iic_en), .role_master(role_master),
        .start_det(start_det), .stop_det(stop_det), .start_gen(start_gen),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_in(sda_in), .sda_drv(sda_drv),
        .local_addr(local_addr), .so_latch(so_latch), .comm_rel(comm_rel),
        .wait_rel(wait_rel), .arb_lost(arb_lost), .xmit_flag(xmit_flag),
        .addr_match(addr_match), .sda_oe(sda_oe), .bit_cnt(bit_cnt)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_addr = 0; m_first = 0; m_x = 0; m_m = 0; m_win = 0;
            en_prev = 0; al_prev = 0;
        end else begin
            ef = en_prev && !iic_en;
            ar = arb_lost && !al_prev;
            r8 = scl_rise && m_first && m_cnt == 7 && !start_det && !stop_det;
            xc = stop_det || comm_rel || wait_rel || ef || ar ||
                 (role_master ? (r8 && sda_drv) : start_det);
            xs = role_master ? start_gen : (r8 && sda_in);
            mc = start_det || stop_det || comm_rel || ef;
            ms = r8 && (m_addr == int'(local_addr));
            if (start_det || stop_det) nwin = 0;
            else if (scl_fall && m_first && m_cnt == 9) nwin = 1;
            else nwin = m_win;
            if (start_det) begin m_cnt = 0; m_first = 1; m_addr = 0; end
            else if (stop_det) m_first = 0;
            else if (scl_rise && m_first && m_cnt < 9) begin
                if (m_cnt < 7) m_addr = (m_addr * 2 + int'(sda_in)) % 128;
                m_cnt = m_cnt + 1;
            end else if (scl_fall && m_first && m_cnt == 9) m_first = 0;
            m_win = nwin;
            if (xc) m_x = 0; else if (xs) m_x = 1;
            if (mc) m_m = 0; else if (ms) m_m = 1;
            en_prev = iic_en;
            al_prev = arb_lost;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #2;
        chk(xmit_flag == m_x, "R7 xmit_flag vs model", xmit_flag, m_x);
        chk(addr_match == m_m, "R3 addr_match vs model", addr_match, m_m);
        chk(sda_oe == (m_x && m_win && !so_latch), "R9 sda_oe vs model", sda_oe,
            int'(m_x && m_win && !so_latch));
        chk(int'(bit_cnt) == m_cnt, "R2 bit_cnt vs model", bit_cnt, m_cnt);
    endtask

    task automatic pulse_start();
        start_det = 1; cyc(); start_det = 0;
    endtask

    task automatic send_byte(input logic [6:0] a, input logic rx_lsb, input logic tx_lsb);
        for (int i = 0; i < 9; i++) begin
            sda_in  = (i < 7) ? a[6-i] : ((i == 7) ? rx_lsb : 1'b0);
            sda_drv = (i < 7) ? a[6-i] : ((i == 7) ? tx_lsb : 1'b1);
            scl_rise = 1; cyc(); scl_rise = 0; cyc();
            scl_fall = 1; cyc(); scl_fall = 0; cyc();
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1; iic_en = 1; role_master = 0; start_det = 0; stop_det = 0; start_gen = 0;
        scl_rise = 0; scl_fall = 0; sda_in = 0; sda_drv = 0; so_latch = 0;
        comm_rel = 0; wait_rel = 0; arb_lost = 0; local_addr = OWN;
        repeat (3) @(posedge clk);
        #2;
        chk(!xmit_flag && !addr_match && !sda_oe && bit_cnt == 0, "R1 reset state",
            {xmit_flag, addr_match, sda_oe, bit_cnt}, 0);
        rst = 0;
        cyc();

        // slave write to own address
        pulse_start();
        chk(bit_cnt == 0, "R2 count zero after start", bit_cnt, 0);
        send_byte(OWN, 1'b0, 1'b0);
        chk(addr_match == 1, "R3 own address matched", addr_match, 1);
        chk(xmit_flag == 0, "R6 write bit keeps receive", xmit_flag, 0);
        chk(bit_cnt == 9, "R2 nine clocks counted", bit_cnt, 9);
        scl_rise = 1; cyc(); scl_rise = 0; cyc();
        chk(bit_cnt == 9, "R2 count saturates", bit_cnt, 9);

        // slave read from own address
        pulse_start();
        chk(addr_match == 0, "R4 start clears match", addr_match, 0);
        send_byte(OWN, 1'b1, 1'b0);
        chk(xmit_flag == 1, "R6 read bit sets transmit", xmit_flag, 1);
        chk(sda_oe == 1, "R9 drive after ninth fall", sda_oe, 1);
        so_latch = 1; cyc();
        chk(sda_oe == 0, "R9 latch one releases SDA", sda_oe, 0);
        so_latch = 0;
        wait_rel = 1; cyc(); wait_rel = 0;
        chk(xmit_flag == 0 && sda_oe == 0, "R7 wait release clears", xmit_flag, 0);

        // mismatch in LSB of address, read
        pulse_start();
        send_byte(OWN ^ 7'h01, 1'b1, 1'b0);
        chk(addr_match == 0, "R3 mismatch not flagged", addr_match, 0);
        chk(xmit_flag == 1, "R6 read sets transmit", xmit_flag, 1);
        comm_rel = 1; cyc(); comm_rel = 0;
        chk(xmit_flag == 0, "R7 comm release clears", xmit_flag, 0);
        pulse_start();
        chk(xmit_flag == 0, "R6 start clears transmit", xmit_flag, 0);

        // stop clears match
        send_byte(OWN, 1'b0, 1'b0);
        stop_det = 1; cyc(); stop_det = 0;
        chk(addr_match == 0, "R4 stop clears match", addr_match, 0);

        // enable falling edge, then held low
        pulse_start();
        send_byte(OWN, 1'b1, 1'b0);
        iic_en = 0; cyc();
        chk(xmit_flag == 0 && addr_match == 0, "R7 enable fall clears both",
            {xmit_flag, addr_match}, 0);
        pulse_start();
        send_byte(OWN, 1'b1, 1'b0);
        chk(xmit_flag == 1, "R7 enable low level does not block", xmit_flag, 1);
        iic_en = 1; cyc();

        // arbitration lost edge, then held high
        arb_lost = 1; cyc();
        chk(xmit_flag == 0, "R7 arbitration rise clears", xmit_flag, 0);
        pulse_start();
        send_byte(OWN, 1'b1, 1'b0);
        chk(xmit_flag == 1, "R7 arbitration high level does not block", xmit_flag, 1);
        arb_lost = 0; cyc();

        // master role
        role_master = 1;
        stop_det = 1; cyc(); stop_det = 0;
        start_gen = 1; start_det = 1; cyc(); start_gen = 0; start_det = 0;
        chk(xmit_flag == 1, "R5 generated start sets transmit", xmit_flag, 1);
        send_byte(7'h51, 1'b0, 1'b1);
        chk(xmit_flag == 0, "R5 driven read bit clears", xmit_flag, 0);
        start_gen = 1; start_det = 1; cyc(); start_gen = 0; start_det = 0;
        send_byte(7'h51, 1'b1, 1'b0);
        chk(xmit_flag == 1, "R5 driven write bit keeps transmit", xmit_flag, 1);

        // conflicting set and clear
        stop_det = 1; cyc(); stop_det = 0;
        start_gen = 1; stop_det = 1; cyc(); start_gen = 0; stop_det = 0;
        chk(xmit_flag == 0, "R8 clear wins over set", xmit_flag, 0);
        start_gen = 1; comm_rel = 1; cyc(); start_gen = 0; comm_rel = 0;
        chk(xmit_flag == 0, "R8 release wins over start", xmit_flag, 0);

        // reset mid-transfer
        role_master = 0;
        pulse_start();
        send_byte(OWN, 1'b1, 1'b0);
        rst = 1; cyc(); rst = 0;
        chk(!xmit_flag && !addr_match && !sda_oe && bit_cnt == 0, "R1 reset mid transfer",
            {xmit_flag, addr_match, sda_oe, bit_cnt}, 0);
        cyc();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule